// File: doc/BRIEF.md
# Message-Based Servant Handshake Registers

This block is the servant half of a 16-bit message-passing register set that sits behind a bus slave. A remote commander reaches it through offsets in a 64-byte A16 configuration window. The commander can read a fixed capability word, read a response word that carries ready and error flags, pass 16-bit words in both directions through a data register, and write signal words. A local processor port raises the ready and error flags, picks up the words the commander wrote, loads the word the commander will read, and takes received signal words.

The ready flags are handshake tokens. The local side can only set them. Each is cleared by the commander's own access to the data register: a read clears read-ready and a write clears write-ready. Every remote data access and every signal write also produces a one-cycle event pulse on the local side.

Top module: `msg_servant_regs`

## Requirements
- R1: After reset, all flags are 0, the inbound word is 0, the outbound word is 0, no signal is pending and no event pulse is high. A response read then returns 0x41FF.
- R2: A remote read at offset 0x08 returns the capability word 0x1FFF. In that word bits 15..13 are 0, bits 12..10 are 1 and bits 9..0 are 1.
- R3: A remote read at offset 0x0A returns a word with these bits: 15 = 0, 14 = 1, 13..12 = 0, 11 = error, 10 = read-ready, 9 = write-ready, 8..0 all ones.
- R4: A local control write (`loc_ctl_we_i`) acts on the bits of `loc_ctl_i`, taking effect at the next clock edge. Bit 0 sets read-ready, bit 1 sets write-ready, bit 2 sets error and bit 3 clears error. When bits 2 and 3 are both 1, error is set.
- R5: A remote read at offset 0x0E clears read-ready at the next edge. If a local set-read-ready arrives in the same cycle, read-ready stays 1.
- R6: A remote write at offset 0x0E stores the word into the inbound register, which appears on `loc_in_data_o` after the next edge. The same write clears write-ready. If a local set-write-ready arrives in the same cycle, write-ready stays 1.
- R7: A remote read at offset 0x0E returns the outbound word last loaded through `loc_out_we_i`. Remote writes never change the outbound word.
- R8: The error flag changes only on a local control write. Remote accesses of any kind leave it unchanged.
- R9: A remote write at offset 0x08 captures the whole 16-bit signal word, whose low 8 bits carry the sender's logical address, and sets the pending flag after the next edge. A one-cycle `loc_sig_pop_i` clears the pending flag. A newer signal word overwrites the older one. If a pop and a new signal arrive in the same cycle, the flag stays pending and holds the new word.
- R10: Each remote data write, remote data read and signal write raises its own event output for exactly the one cycle that follows the access.
- R11: A remote read at any other offset, including any odd offset, returns 0, and so does the bus when no read is in progress. A remote write to any offset other than 0x08 and 0x0E has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rbus_sel_i | input | 1 | Remote access strobe, one cycle per access |
| rbus_we_i | input | 1 | Remote access is a write |
| rbus_addr_i | input | 6 | Byte offset within the 64-byte window |
| rbus_wdata_i | input | 16 | Remote write data |
| rbus_rdata_o | output | 16 | Remote read data, valid in the strobe cycle |
| loc_ctl_we_i | input | 1 | Local control write strobe |
| loc_ctl_i | input | 4 | Control bits: set read-ready, set write-ready, set error, clear error |
| loc_out_we_i | input | 1 | Load outbound word |
| loc_out_data_i | input | 16 | Outbound word for the commander to read |
| loc_in_data_o | output | 16 | Last word the commander wrote |
| loc_sig_pop_i | input | 1 | Take the pending signal word |
| loc_sig_data_o | output | 16 | Last captured signal word |
| loc_sig_pend_o | output | 1 | A signal word is waiting |
| evt_data_wr_o | output | 1 | Pulse after a remote data write |
| evt_data_rd_o | output | 1 | Pulse after a remote data read |
| evt_sig_o | output | 1 | Pulse after a signal write |

## Verification
The hardest situations to reach are the collisions between a local set and a remote clear in the same cycle, and between a pop and a fresh signal word in the same cycle. Sequential port traffic never produces either one. The bench drives both sides inside a single clock period to create them. It then reads the response word back through the remote port to confirm that the set won and that the error flag stayed untouched.

// File: rtl/msr_pkg.sv
package msr_pkg;
  localparam int DW    = 16;
  localparam int AW    = 6;
  localparam int CTL_W = 4;

  localparam logic [AW-1:0] OFS_PROT = 6'h08;  // read: capability, write: signal
  localparam logic [AW-1:0] OFS_RESP = 6'h0A;
  localparam logic [AW-1:0] OFS_DATA = 6'h0E;

  localparam logic [DW-1:0] PROT_WORD = 16'h1FFF;
  localparam logic [DW-1:0] RESP_BASE = 16'h41FF;
  localparam int RESP_ERR  = 11;
  localparam int RESP_RRDY = 10;
  localparam int RESP_WRDY = 9;

  localparam int CTL_SET_RRDY = 0;
  localparam int CTL_SET_WRDY = 1;
  localparam int CTL_SET_ERR  = 2;
  localparam int CTL_CLR_ERR  = 3;

  typedef struct packed {
    logic prot_rd;
    logic resp_rd;
    logic data_rd;
    logic data_wr;
    logic sig_wr;
  } acc_t;
endpackage

// File: rtl/msr_decode.sv
module msr_decode
  import msr_pkg::*;
(
  input  logic          sel_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  output acc_t          acc_o
);
  logic rd, wr;
  assign rd = sel_i & ~we_i;
  assign wr = sel_i & we_i;

  always_comb begin
    acc_o         = '0;
    acc_o.prot_rd = rd & (addr_i == OFS_PROT);
    acc_o.resp_rd = rd & (addr_i == OFS_RESP);
    acc_o.data_rd = rd & (addr_i == OFS_DATA);
    acc_o.data_wr = wr & (addr_i == OFS_DATA);
    acc_o.sig_wr  = wr & (addr_i == OFS_PROT);
  end
endmodule

// File: rtl/msr_flags.sv
module msr_flags
  import msr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctl_we_i,
  input  logic [CTL_W-1:0] ctl_i,
  input  logic             data_rd_i,
  input  logic             data_wr_i,
  output logic             rrdy_o,
  output logic             wrdy_o,
  output logic             err_o
);
  logic set_r, set_w, set_e, clr_e;
  assign set_r = ctl_we_i & ctl_i[CTL_SET_RRDY];
  assign set_w = ctl_we_i & ctl_i[CTL_SET_WRDY];
  assign set_e = ctl_we_i & ctl_i[CTL_SET_ERR];
  assign clr_e = ctl_we_i & ctl_i[CTL_CLR_ERR];

  // local set wins over any clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rrdy_o <= 1'b0;
      wrdy_o <= 1'b0;
      err_o  <= 1'b0;
    end else begin
      if (set_r)          rrdy_o <= 1'b1;
      else if (data_rd_i) rrdy_o <= 1'b0;
      if (set_w)          wrdy_o <= 1'b1;
      else if (data_wr_i) wrdy_o <= 1'b0;
      if (set_e)          err_o  <= 1'b1;
      else if (clr_e)     err_o  <= 1'b0;
    end
  end
endmodule

// File: rtl/msr_sig_capture.sv
module msr_sig_capture #(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sig_wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          pop_i,
  output logic [DW-1:0] sig_o,
  output logic          pend_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sig_o  <= '0;
      pend_o <= 1'b0;
    end else if (sig_wr_i) begin
      sig_o  <= wdata_i;
      pend_o <= 1'b1;
    end else if (pop_i) begin
      pend_o <= 1'b0;
    end
  end
endmodule

// File: rtl/msg_servant_regs.sv
module msg_servant_regs
  import msr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rbus_sel_i,
  input  logic             rbus_we_i,
  input  logic [AW-1:0]    rbus_addr_i,
  input  logic [DW-1:0]    rbus_wdata_i,
  output logic [DW-1:0]    rbus_rdata_o,
  input  logic             loc_ctl_we_i,
  input  logic [CTL_W-1:0] loc_ctl_i,
  input  logic             loc_out_we_i,
  input  logic [DW-1:0]    loc_out_data_i,
  output logic [DW-1:0]    loc_in_data_o,
  input  logic             loc_sig_pop_i,
  output logic [DW-1:0]    loc_sig_data_o,
  output logic             loc_sig_pend_o,
  output logic             evt_data_wr_o,
  output logic             evt_data_rd_o,
  output logic             evt_sig_o
);
  acc_t          acc;
  logic          rrdy, wrdy, err;
  logic [DW-1:0] in_q, out_q, resp_word;

  msr_decode u_decode (
    .sel_i  (rbus_sel_i),
    .we_i   (rbus_we_i),
    .addr_i (rbus_addr_i),
    .acc_o  (acc)
  );

  msr_flags u_flags (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ctl_we_i  (loc_ctl_we_i),
    .ctl_i     (loc_ctl_i),
    .data_rd_i (acc.data_rd),
    .data_wr_i (acc.data_wr),
    .rrdy_o    (rrdy),
    .wrdy_o    (wrdy),
    .err_o     (err)
  );

  msr_sig_capture #(.DW(DW)) u_sig (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sig_wr_i (acc.sig_wr),
    .wdata_i  (rbus_wdata_i),
    .pop_i    (loc_sig_pop_i),
    .sig_o    (loc_sig_data_o),
    .pend_o   (loc_sig_pend_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_q          <= '0;
      out_q         <= '0;
      evt_data_wr_o <= 1'b0;
      evt_data_rd_o <= 1'b0;
      evt_sig_o     <= 1'b0;
    end else begin
      if (acc.data_wr) in_q  <= rbus_wdata_i;
      if (loc_out_we_i) out_q <= loc_out_data_i;
      evt_data_wr_o <= acc.data_wr;
      evt_data_rd_o <= acc.data_rd;
      evt_sig_o     <= acc.sig_wr;
    end
  end

  always_comb begin
    resp_word            = RESP_BASE;
    resp_word[RESP_ERR]  = err;
    resp_word[RESP_RRDY] = rrdy;
    resp_word[RESP_WRDY] = wrdy;
  end

  always_comb begin
    unique case (1'b1)
      acc.prot_rd: rbus_rdata_o = PROT_WORD;
      acc.resp_rd: rbus_rdata_o = resp_word;
      acc.data_rd: rbus_rdata_o = out_q;
      default:     rbus_rdata_o = '0;
    endcase
  end

  assign loc_in_data_o = in_q;
endmodule

// File: rtl/msr_chk.sv
module msr_chk
  import msr_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             rbus_sel_i,
  input logic             rbus_we_i,
  input logic [AW-1:0]    rbus_addr_i,
  input logic [DW-1:0]    rbus_wdata_i,
  input logic [DW-1:0]    rbus_rdata_o,
  input logic             loc_ctl_we_i,
  input logic [CTL_W-1:0] loc_ctl_i,
  input logic [DW-1:0]    loc_sig_data_o,
  input logic             loc_sig_pend_o,
  input logic             evt_data_wr_o,
  input logic             evt_data_rd_o,
  input logic             evt_sig_o,
  input logic             rrdy,
  input logic             wrdy,
  input logic             err
);
  logic rd_data, wr_data, wr_sig, rd_other;
  assign rd_data  = rbus_sel_i && !rbus_we_i && rbus_addr_i == OFS_DATA;
  assign wr_data  = rbus_sel_i && rbus_we_i && rbus_addr_i == OFS_DATA;
  assign wr_sig   = rbus_sel_i && rbus_we_i && rbus_addr_i == OFS_PROT;
  assign rd_other = rbus_sel_i && !rbus_we_i && rbus_addr_i != OFS_PROT
                    && rbus_addr_i != OFS_RESP && rbus_addr_i != OFS_DATA;

  // R2
  prot_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rbus_sel_i && !rbus_we_i && rbus_addr_i == OFS_PROT) |-> rbus_rdata_o == 16'h1FFF);

  // R3
  resp_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rbus_sel_i && !rbus_we_i && rbus_addr_i == OFS_RESP)
      |-> rbus_rdata_o == {4'b0100, err, rrdy, wrdy, 9'h1FF});

  // R5
  rrdy_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data && !(loc_ctl_we_i && loc_ctl_i[CTL_SET_RRDY])) |=> !rrdy);

  // R6
  wrdy_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_data && !(loc_ctl_we_i && loc_ctl_i[CTL_SET_WRDY])) |=> !wrdy);

  // R8
  err_local_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !loc_ctl_we_i |=> $stable(err));

  // R9
  sig_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_sig |=> (loc_sig_pend_o && loc_sig_data_o == $past(rbus_wdata_i)));

  // R10
  evt_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) || (evt_sig_o == $past(wr_sig) && evt_data_wr_o == $past(wr_data)
      && evt_data_rd_o == $past(rd_data)) || !$past(rst_ni));

  // R10
  evt_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({evt_sig_o, evt_data_wr_o, evt_data_rd_o}));

  // R11
  unmapped_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_other |-> rbus_rdata_o == '0);
endmodule

bind msg_servant_regs msr_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .rbus_sel_i     (rbus_sel_i),
  .rbus_we_i      (rbus_we_i),
  .rbus_addr_i    (rbus_addr_i),
  .rbus_wdata_i   (rbus_wdata_i),
  .rbus_rdata_o   (rbus_rdata_o),
  .loc_ctl_we_i   (loc_ctl_we_i),
  .loc_ctl_i      (loc_ctl_i),
  .loc_sig_data_o (loc_sig_data_o),
  .loc_sig_pend_o (loc_sig_pend_o),
  .evt_data_wr_o  (evt_data_wr_o),
  .evt_data_rd_o  (evt_data_rd_o),
  .evt_sig_o      (evt_sig_o),
  .rrdy           (rrdy),
  .wrdy           (wrdy),
  .err            (err)
);

// File: tb/msg_servant_regs_bench.sv
module msg_servant_regs_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        rbus_sel_i = 1'b0, rbus_we_i = 1'b0;
  logic [5:0]  rbus_addr_i = '0;
  logic [15:0] rbus_wdata_i = '0, rbus_rdata_o;
  logic        loc_ctl_we_i = 1'b0;
  logic [3:0]  loc_ctl_i = '0;
  logic        loc_out_we_i = 1'b0;
  logic [15:0] loc_out_data_i = '0, loc_in_data_o, loc_sig_data_o;
  logic        loc_sig_pop_i = 1'b0, loc_sig_pend_o;
  logic        evt_data_wr_o, evt_data_rd_o, evt_sig_o;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  msg_servant_regs u_msg_servant_regs (.*);

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic rd(logic [5:0] a, output logic [15:0] d);
    @(negedge clk_i);
    rbus_sel_i = 1; rbus_we_i = 0; rbus_addr_i = a;
    #1 d = rbus_rdata_o;
    @(negedge clk_i);
    rbus_sel_i = 0;
  endtask

  task automatic wr(logic [5:0] a, logic [15:0] d);
    @(negedge clk_i);
    rbus_sel_i = 1; rbus_we_i = 1; rbus_addr_i = a; rbus_wdata_i = d;
    @(negedge clk_i);
    rbus_sel_i = 0; rbus_we_i = 0;
  endtask

  task automatic ctl(logic [3:0] c);
    @(negedge clk_i);
    loc_ctl_we_i = 1; loc_ctl_i = c;
    @(negedge clk_i);
    loc_ctl_we_i = 0; loc_ctl_i = '0;
  endtask

  task automatic resp_is(string req, logic [15:0] exp);
    logic [15:0] d;
    rd(6'h0A, d);
    chk(req, d, exp);
  endtask

  task automatic t_reset();
    chk("R1 inbound", loc_in_data_o, 16'h0);
    chk("R1 pending", {15'b0, loc_sig_pend_o}, 16'h0);
    chk("R1 events", {13'b0, evt_data_wr_o, evt_data_rd_o, evt_sig_o}, 16'h0);
    resp_is("R1 response", 16'h41FF);
  endtask

  task automatic t_protocol();
    logic [15:0] d;
    rd(6'h08, d);
    chk("R2 capability", d, 16'h1FFF);
  endtask

  task automatic t_flags();
    ctl(4'b0111); resp_is("R4 set all (R3 layout)", 16'h4FFF);
    ctl(4'b1000); resp_is("R4 clear err", 16'h47FF);
    ctl(4'b1100); resp_is("R4 set beats clear", 16'h4FFF);
    ctl(4'b1000); resp_is("R4 clear err again", 16'h47FF);
  endtask

  task automatic t_data_out();
    logic [15:0] d;
    @(negedge clk_i); loc_out_we_i = 1; loc_out_data_i = 16'hA5C3;
    @(negedge clk_i); loc_out_we_i = 0;
    @(negedge clk_i);
    rbus_sel_i = 1; rbus_we_i = 0; rbus_addr_i = 6'h0E;
    #1 d = rbus_rdata_o;
    @(negedge clk_i); rbus_sel_i = 0;
    chk("R7 outbound read", d, 16'hA5C3);
    chk("R10 read pulse", {14'b0, evt_data_rd_o, evt_data_wr_o}, 16'h2);
    @(negedge clk_i);
    chk("R10 read pulse width", {15'b0, evt_data_rd_o}, 16'h0);
    resp_is("R5 read clears rrdy, R8 err kept", 16'h43FF);
  endtask

  task automatic t_data_in();
    logic [15:0] d;
    @(negedge clk_i);
    rbus_sel_i = 1; rbus_we_i = 1; rbus_addr_i = 6'h0E; rbus_wdata_i = 16'h1234;
    @(negedge clk_i); rbus_sel_i = 0; rbus_we_i = 0;
    chk("R10 write pulse", {14'b0, evt_data_wr_o, evt_sig_o}, 16'h2);
    chk("R6 inbound", loc_in_data_o, 16'h1234);
    @(negedge clk_i);
    chk("R10 write pulse width", {15'b0, evt_data_wr_o}, 16'h0);
    resp_is("R6 write clears wrdy", 16'h41FF);
    rd(6'h0E, d);
    chk("R7 outbound untouched by write", d, 16'hA5C3);
  endtask

  task automatic t_collide();
    ctl(4'b0100);
    resp_is("R4 set err", 16'h49FF);
    @(negedge clk_i);
    loc_ctl_we_i = 1; loc_ctl_i = 4'b0001;
    rbus_sel_i = 1; rbus_we_i = 0; rbus_addr_i = 6'h0E;
    @(negedge clk_i);
    loc_ctl_we_i = 0; loc_ctl_i = '0; rbus_sel_i = 0;
    resp_is("R5 local set beats remote read", 16'h4DFF);
    rd(6'h0E, loc_out_data_i);
    resp_is("R5 later read clears", 16'h49FF);
    @(negedge clk_i);
    loc_ctl_we_i = 1; loc_ctl_i = 4'b0010;
    rbus_sel_i = 1; rbus_we_i = 1; rbus_addr_i = 6'h0E; rbus_wdata_i = 16'h0F0F;
    @(negedge clk_i);
    loc_ctl_we_i = 0; loc_ctl_i = '0; rbus_sel_i = 0; rbus_we_i = 0;
    resp_is("R6 local set beats remote write, R8 err kept", 16'h4BFF);
    chk("R6 inbound on collision", loc_in_data_o, 16'h0F0F);
    ctl(4'b1000);
    resp_is("R8 local clear err", 16'h43FF);
  endtask

  task automatic t_signal();
    wr(6'h08, 16'hBEEF);
    chk("R10 signal pulse", {13'b0, evt_sig_o, evt_data_wr_o, evt_data_rd_o}, 16'h4);
    chk("R9 pending", {15'b0, loc_sig_pend_o}, 16'h1);
    chk("R9 word", loc_sig_data_o, 16'hBEEF);
    wr(6'h08, 16'h0177);
    chk("R9 overwrite", loc_sig_data_o, 16'h0177);
    @(negedge clk_i); loc_sig_pop_i = 1;
    @(negedge clk_i); loc_sig_pop_i = 0;
    chk("R9 pop clears", {15'b0, loc_sig_pend_o}, 16'h0);
    @(negedge clk_i);
    loc_sig_pop_i = 1;
    rbus_sel_i = 1; rbus_we_i = 1; rbus_addr_i = 6'h08; rbus_wdata_i = 16'h2203;
    @(negedge clk_i);
    loc_sig_pop_i = 0; rbus_sel_i = 0; rbus_we_i = 0;
    chk("R9 new word beats pop", {loc_sig_pend_o, loc_sig_data_o[14:0]}, 16'hA203);
    resp_is("R11 signal leaves response", 16'h43FF);
    chk("R11 signal leaves inbound", loc_in_data_o, 16'h0F0F);
  endtask

  task automatic t_unmapped();
    logic [15:0] d;
    rd(6'h00, d); chk("R11 read 0x00", d, 16'h0);
    rd(6'h3C, d); chk("R11 read 0x3C", d, 16'h0);
    rd(6'h09, d); chk("R11 read odd", d, 16'h0);
    #1 chk("R11 idle bus", rbus_rdata_o, 16'h0);
    wr(6'h0A, 16'h0000);
    wr(6'h00, 16'hFFFF);
    wr(6'h0F, 16'h5555);
    chk("R11 no event", {13'b0, evt_data_wr_o, evt_data_rd_o, evt_sig_o}, 16'h0);
    resp_is("R11 response kept", 16'h43FF);
    chk("R11 inbound kept", loc_in_data_o, 16'h0F0F);
    chk("R11 signal kept", {loc_sig_pend_o, loc_sig_data_o[14:0]}, 16'hA203);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_protocol();
    t_flags();
    t_data_out();
    t_data_in();
    t_collide();
    t_signal();
    t_unmapped();
    repeat (2) @(negedge clk_i);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog (R1..R11 run): actual hung, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule